// File: doc/BRIEF.md
# Run-Time Selectable Signed/Unsigned Comparator

This block orders two operands of a parameterised width, 4 bits by default. A one-bit mode input chooses how the bit patterns are read. When the mode is low, the operands are plain unsigned numbers. When it is high, they are two's-complement values. The block reports the result on three flags: equal, greater-than and less-than.

A single subtractor serves both modes. Each operand is first widened by one bit. In unsigned mode the new top bit is zero. In signed mode the operand's own top bit is copied into it. The widened difference cannot overflow, so its top bit gives the ordering and a NOR over all of its bits gives equality.

The flags and an output-valid strobe are registered. A pair presented with the input-valid strobe high appears on the flags one clock later. While the input-valid strobe is low, the flags keep their last value.

Top module: `sgn_mag_cmp`

## Requirements
- R1: With `mode_signed` = 0, both operands are read as unsigned; `gt` is high exactly when a > b and `lt` exactly when a < b.
- R2: With `mode_signed` = 1, both operands are read as two's-complement (bit W-1 is the sign); `gt` and `lt` follow the signed ordering.
- R3: `eq` is high exactly when the two bit patterns are identical, in either mode.
- R4: Whenever `out_valid` is high, exactly one of `eq`, `gt`, `lt` is high.
- R5: The pattern 1000 against 0111 (W=4) gives `lt` in signed mode and `gt` in unsigned mode.
- R6: All-zeros against all-ones gives `lt` in unsigned mode and `gt` in signed mode (0 > -1).
- R7: Operands sampled at a rising edge with `in_valid` high set the flags at that edge, and `out_valid` is high from that edge until the next one.
- R8: A rising edge with `in_valid` low leaves the flags unchanged, whatever the operands and the mode are, and drives `out_valid` low.
- R9: A rising edge with `rst` high clears all three flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode_signed | input | 1 | 0 = unsigned, 1 = two's complement |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Flags hold a result captured on the previous edge |
| eq | output | 1 | a equals b |
| gt | output | 1 | a greater than b |
| lt | output | 1 | a less than b |

## Verification
The result assertions assume that `a`, `b` and `mode_signed` carry known values whenever `in_valid` is high. They also assume that `rst` is high at the first clock edge, so the one-cycle look-back starts from a defined state. The bench drives every input at the falling edge from time zero, with reset asserted and with no X on any input. It sweeps all operand pairs in both modes. It then changes operands and mode while `in_valid` is low, to show that the held result stays put.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_CLEAR = '{lt: 1'b0, gt: 1'b0, eq: 1'b0};
endpackage

// File: rtl/cmp_widen.sv
// Adds one bit above the operand: zero for unsigned, a copy of the MSB for signed.
module cmp_widen #(
  parameter int W = 4
) (
  input  logic [W-1:0] opnd,
  input  logic         as_signed,
  output logic [W:0]   wide
);
  always_comb begin
    wide = {as_signed & opnd[W-1], opnd};
  end
endmodule

// File: rtl/cmp_subtract.sv
// A W+1 bit difference of two widened operands never overflows.
module cmp_subtract #(
  parameter int W = 4
) (
  input  logic [W:0] lhs,
  input  logic [W:0] rhs,
  output logic [W:0] diff
);
  always_comb begin
    diff = lhs - rhs;
  end
endmodule

// File: rtl/cmp_decode.sv
module cmp_decode
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W:0]  diff,
  output cmp_flags_t  flags
);
  logic zero;

  always_comb begin
    flags    = FLAGS_CLEAR;
    zero     = ~|diff;
    flags.eq = zero;
    flags.lt = diff[W];
    flags.gt = ~zero & ~diff[W];
  end
endmodule

// File: rtl/sgn_mag_cmp.sv
module sgn_mag_cmp
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         mode_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic         eq,
  output logic         gt,
  output logic         lt
);
  localparam int WX = W + 1;

  logic [WX-1:0] a_wide;
  logic [WX-1:0] b_wide;
  logic [WX-1:0] diff;
  cmp_flags_t    next_flags;
  cmp_flags_t    flags_q;
  logic          valid_q;

  cmp_widen #(.W(W)) u_widen_a (.opnd(a), .as_signed(mode_signed), .wide(a_wide));
  cmp_widen #(.W(W)) u_widen_b (.opnd(b), .as_signed(mode_signed), .wide(b_wide));

  cmp_subtract #(.W(W)) u_sub (.lhs(a_wide), .rhs(b_wide), .diff(diff));

  cmp_decode #(.W(W)) u_dec (.diff(diff), .flags(next_flags));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_CLEAR;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) flags_q <= next_flags;
    end
  end

  assign out_valid = valid_q;
  assign eq        = flags_q.eq;
  assign gt        = flags_q.gt;
  assign lt        = flags_q.lt;
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         mode_signed,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         out_valid,
  input logic         eq,
  input logic         gt,
  input logic         lt
);
  logic ref_gt, ref_lt;
  always_comb begin
    if (mode_signed) begin
      ref_gt = $signed(a) > $signed(b);
      ref_lt = $signed(a) < $signed(b);
    end else begin
      ref_gt = a > b;
      ref_lt = a < b;
    end
  end

  // R1 R2: ordering follows the selected interpretation
  a_r1_r2_gt: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (gt == $past(ref_gt)));
  a_r1_r2_lt: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (lt == $past(ref_lt)));
  a_r3_equal: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (eq == ($past(a) == $past(b))));
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({eq, gt, lt}) == 1));
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable({eq, gt, lt}) && !out_valid));
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && !eq && !gt && !lt));
endmodule

bind sgn_mag_cmp cmp_checker #(.W(W)) u_chk (.*);

// File: tb/tb_sgn_mag_cmp.sv
`timescale 1ns/1ps
module tb_sgn_mag_cmp;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic mode_signed = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic out_valid, eq, gt, lt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sgn_mag_cmp #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_signed(mode_signed),
    .a(a), .b(b), .out_valid(out_valid), .eq(eq), .gt(gt), .lt(lt)
  );

  function automatic int to_val(input logic [W-1:0] x, input logic sgn);
    int v = int'(x);
    if (sgn && x[W-1]) v = v - N;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {v,eq,gt,lt}=%b expected=%b", req, act, exp);
    end
  endtask

  // Present one pair, then sample flags one edge later.
  task automatic apply(input logic m, input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    int va, vb;
    logic [3:0] exp;
    @(negedge clk);
    in_valid = 1'b1; mode_signed = m; a = x; b = y;
    @(negedge clk);
    in_valid = 1'b0;
    va = to_val(x, m);
    vb = to_val(y, m);
    exp = {1'b1, va == vb, va > vb, va < vb};
    check({out_valid, eq, gt, lt} == exp, req, {out_valid, eq, gt, lt}, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({out_valid, eq, gt, lt} == 4'b0000, "R9 reset state", {out_valid, eq, gt, lt}, 4'b0000);
    rst = 1'b0;
  endtask

  task automatic t_sweep(input logic m);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        apply(m, W'(i), W'(j), m ? "R2 R3 R4 R7 signed sweep" : "R1 R3 R4 R7 unsigned sweep");
  endtask

  task automatic t_corner();
    apply(1'b1, 4'b1000, 4'b0111, "R5 signed min vs max");
    check(lt && !gt, "R5 signed lt", {out_valid, eq, gt, lt}, 4'b1001);
    apply(1'b0, 4'b1000, 4'b0111, "R5 unsigned 1000 vs 0111");
    check(gt && !lt, "R5 unsigned gt", {out_valid, eq, gt, lt}, 4'b1010);
  endtask

  task automatic t_extremes();
    apply(1'b0, 4'b0000, 4'b1111, "R6 unsigned 0 vs 15");
    check(lt, "R6 unsigned lt", {out_valid, eq, gt, lt}, 4'b1001);
    apply(1'b1, 4'b0000, 4'b1111, "R6 signed 0 vs -1");
    check(gt, "R6 signed gt", {out_valid, eq, gt, lt}, 4'b1010);
  endtask

  task automatic t_hold();
    apply(1'b0, 4'd9, 4'd3, "R1 hold setup");
    @(negedge clk);
    in_valid = 1'b0; mode_signed = 1'b1; a = 4'd1; b = 4'd9;
    @(negedge clk);
    check({out_valid, eq, gt, lt} == 4'b0010, "R8 flags held, valid low",
          {out_valid, eq, gt, lt}, 4'b0010);
    a = 4'd5; b = 4'd5; mode_signed = 1'b0;
    @(negedge clk);
    check({out_valid, eq, gt, lt} == 4'b0010, "R8 still held",
          {out_valid, eq, gt, lt}, 4'b0010);
  endtask

  task automatic t_midreset();
    apply(1'b0, 4'd2, 4'd2, "R3 before reset");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; a = 4'd7; b = 4'd1;
    @(negedge clk);
    check({out_valid, eq, gt, lt} == 4'b0000, "R9 reset clears",
          {out_valid, eq, gt, lt}, 4'b0000);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_corner();
        t_extremes();
        t_hold();
        t_midreset();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule